// File: doc/BRIEF.md
# Multi-Width Serial Flash Byte Shifter

This block moves one byte between a command sequencer and a serial flash device. The byte travels over one, two or four bidirectional data lines, and the width is chosen per byte. The block generates the serial clock from a programmable divider. It sets the output enable of each of the four data lines for the chosen width and direction. The lines that serve as write-protect and hold are kept driven high whenever they carry no data. Chip-select framing, opcodes and addresses are handled by the sequencer, not by this block.

Requests enter through a valid/ready handshake. `req_ready` is high only while no byte is in flight. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. The width, direction, transmit byte and divider are sampled in that same cycle. While a byte is in progress, `req_ready` is low and the request fields may change freely. The sequencer must hold `req_valid` and its fields until it sees `req_ready`. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse and the sequencer must take `rsp_byte` in that cycle. In the pulse cycle `req_ready` is already high, so the next byte can be accepted with no idle gap.

Top module: `spi_byte_shifter`

## Requirements
- R1: `sck` is low whenever no byte is in flight. During a byte, each low phase and each high phase of `sck` lasts `div_half`+1 system clocks, using the divider value latched at acceptance. Every serial clock of a byte starts with its low phase.
- R2: Width code 0 selects single mode. It uses eight serial clocks per byte. Bit 7 is driven first on line 0, then the remaining bits in falling order. Line 1 is an input throughout, and its value is the one received.
- R3: Received data is sampled in the last system clock of each `sck` high phase, just before the falling edge. The sampled bits are assembled most significant first into `rsp_byte`. In dual mode the bits come from lines 1 (higher) and 0 (lower). In quad mode they come from lines 3 down to 0, with line 3 holding the highest bit.
- R4: In single mode with `req_rx` set, line 0 is driven to all ones during the byte, whatever the value of `req_byte`.
- R5: Width code 1 selects dual mode. It uses four serial clocks per byte. On a transmit byte, line 1 carries the higher bit of each pair and line 0 the lower, starting from bits 7:6.
- R6: Width codes 2 and 3 select quad mode. It uses two serial clocks per byte. On a transmit byte, lines 3..0 carry bits 7..4 first and then bits 3..0.
- R7: Output enables (bit n drives line n) during a byte are: single `1101`, dual transmit `1111`, dual receive `1100`, quad transmit `1111`, quad receive `0000`. When idle the enables are `1101`, with line 0 driven high.
- R8: Whenever lines 2 and 3 carry no data, they are driven high with their enables set. This applies when idle, in single mode and in dual mode.
- R9: `rsp_valid` is high for exactly one cycle, in the cycle right after the edge where `sck` falls for the last time in the byte. `rsp_byte` is valid in that cycle.
- R10: `req_ready` is low from the cycle after acceptance until the final falling edge. A `req_valid` presented while it is low has no effect on the byte in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| div_half | input | DIV_W | Serial clock half period minus one, in system clocks |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_width | input | 2 | 0 single, 1 dual, 2 or 3 quad |
| req_rx | input | 1 | Receive byte (single: drive ones; dual/quad: release lines) |
| req_byte | input | BYTE_W | Byte to transmit |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_byte | output | BYTE_W | Assembled received byte |
| sck | output | 1 | Serial clock to the flash |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The main function is exercised with all four width codes, both directions, and a range of divider values. The divider values include the minimum of zero and the maximum, which separates phase-length errors from lane-mapping errors. `io_in` is given a new random value on every system clock. This means the received byte matches only if sampling happens in the exact final high-phase cycle, so an early or late sample is exposed. Requests are held valid while a byte is in flight and sometimes land in the completion cycle. This tests both that busy-time requests are ignored and that a new byte can be accepted back to back. Single-mode receives carry random transmit bytes, which shows whether line 0 is really forced to ones.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  typedef enum logic [1:0] {
    LM_X1 = 2'd0,
    LM_X2 = 2'd1,
    LM_X4 = 2'd2
  } lane_mode_e;

  function automatic lane_mode_e decode_width(input logic [1:0] code);
    case (code)
      2'd0:    return LM_X1;
      2'd1:    return LM_X2;
      default: return LM_X4;
    endcase
  endfunction
endpackage

// File: rtl/ssh_clkgen.sv
module ssh_clkgen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sck,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             at_end;

  assign at_end = (cnt_q == half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (run) begin
      if (at_end) begin
        cnt_q <= '0;
        sck_q <= ~sck_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sck  = sck_q;
  assign fall = run && sck_q && at_end;
endmodule

// File: rtl/ssh_lanes.sv
module ssh_lanes
  import spi_shift_pkg::*;
(
  input  logic       busy,
  input  lane_mode_e mode,
  input  logic       rx,
  input  logic [3:0] nib,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);
  always_comb begin
    io_out = 4'b1101;
    io_oe  = 4'b1101;
    if (busy) begin
      case (mode)
        LM_X1: begin
          io_out = {2'b11, 1'b0, nib[3]};
          io_oe  = 4'b1101;
        end
        LM_X2: begin
          io_out = {2'b11, nib[3], nib[2]};
          io_oe  = rx ? 4'b1100 : 4'b1111;
        end
        default: begin
          io_out = nib;
          io_oe  = rx ? 4'b0000 : 4'b1111;
        end
      endcase
    end
  end
endmodule

// File: rtl/ssh_sampler.sv
module ssh_sampler
  import spi_shift_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  lane_mode_e        mode,
  input  logic [3:0]        io_in,
  output logic [BYTE_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (capture) begin
      case (mode)
        LM_X1:   acc <= {acc[BYTE_W-2:0], io_in[1]};
        LM_X2:   acc <= {acc[BYTE_W-3:0], io_in[1:0]};
        default: acc <= {acc[BYTE_W-5:0], io_in};
      endcase
    end
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_shift_pkg::*;
#(
  parameter int DIV_W  = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_width,
  input  logic              req_rx,
  input  logic [BYTE_W-1:0] req_byte,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_byte,
  output logic              sck,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  localparam int BEAT_W = $clog2(BYTE_W);

  logic              busy_q;
  lane_mode_e        mode_q;
  logic              rx_q;
  logic [DIV_W-1:0]  half_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] last_beat;
  logic              rsp_valid_q;
  logic              accept;
  logic              fall;
  lane_mode_e        req_mode;

  assign req_mode  = decode_width(req_width);
  assign accept    = req_valid && !busy_q;
  assign req_ready = !busy_q;

  always_comb begin
    case (mode_q)
      LM_X1:   last_beat = BEAT_W'(BYTE_W - 1);
      LM_X2:   last_beat = BEAT_W'(BYTE_W / 2 - 1);
      default: last_beat = BEAT_W'(BYTE_W / 4 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      mode_q      <= LM_X1;
      rx_q        <= 1'b0;
      half_q      <= '0;
      tx_q        <= '0;
      beat_q      <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        mode_q <= req_mode;
        rx_q   <= req_rx;
        half_q <= div_half;
        beat_q <= '0;
        tx_q   <= (req_mode == LM_X1 && req_rx) ? '1 : req_byte;
      end else if (fall) begin
        beat_q <= beat_q + 1'b1;
        case (mode_q)
          LM_X1:   tx_q <= tx_q << 1;
          LM_X2:   tx_q <= tx_q << 2;
          default: tx_q <= tx_q << 4;
        endcase
        if (beat_q == last_beat) begin
          busy_q      <= 1'b0;
          rsp_valid_q <= 1'b1;
        end
      end
    end
  end

  assign rsp_valid = rsp_valid_q;

  ssh_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .run   (busy_q),
    .half  (half_q),
    .sck   (sck),
    .fall  (fall)
  );

  ssh_lanes u_lanes (
    .busy   (busy_q),
    .mode   (mode_q),
    .rx     (rx_q),
    .nib    (tx_q[BYTE_W-1 -: 4]),
    .io_out (io_out),
    .io_oe  (io_oe)
  );

  ssh_sampler #(.BYTE_W(BYTE_W)) u_samp (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (fall),
    .mode    (mode_q),
    .io_in   (io_in),
    .acc     (rsp_byte)
  );
endmodule

// File: rtl/ssh_checker.sv
module ssh_checker
  import spi_shift_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input lane_mode_e mode_q,
  input logic       rx_q
);
  AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !sck); // R1

  AST_HIGH_PHASE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(io_out)); // R3

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9

  AST_RSP_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R10

  AST_AUX_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || mode_q != LM_X4) |-> (io_oe[3:2] == 2'b11 && io_out[3:2] == 2'b11)); // R8

  AST_QUAD_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && mode_q == LM_X4 && rx_q) |-> (io_oe == 4'b0000)); // R7

  AST_SINGLE_LINE1_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || mode_q == LM_X1) |-> !io_oe[1]); // R2
endmodule

bind spi_byte_shifter ssh_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sck       (sck),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .io_out    (io_out),
  .io_oe     (io_oe),
  .mode_q    (mode_q),
  .rx_q      (rx_q)
);

// File: tb/tb_spi_byte_shifter.sv
module tb_spi_byte_shifter;
  localparam int PERIOD = 10;
  localparam int DIV_W  = 4;
  localparam int STEPS  = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_half = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_width = '0;
  logic       req_rx = 1'b0;
  logic [7:0] req_byte = '0;
  logic       rsp_valid;
  logic [7:0] rsp_byte;
  logic       sck;
  logic [3:0] io_out;
  logic [3:0] io_oe;
  logic [3:0] io_in = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model state
  bit         m_busy = 0;
  int         m_c = 0, m_h = 1, m_k = 1, m_w = 0;
  bit         m_rx = 0;
  int         m_tx = 0, m_acc = 0, m_rsp = 0;
  bit         m_rspv = 0;

  always #(PERIOD/2) clk = ~clk;

  spi_byte_shifter #(.DIV_W(DIV_W), .BYTE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .div_half(div_half),
    .req_valid(req_valid), .req_ready(req_ready), .req_width(req_width),
    .req_rx(req_rx), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_byte(rsp_byte), .sck(sck), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int p, b, bits, eoe;
    logic [7:0] sh;
    int r;
    @(negedge clk);
    // compare against model
    if (m_busy) begin
      p  = m_c / m_h;
      b  = p / 2;
      sh = 8'((m_tx << (b * m_k)) & 255);
      check(sck === (p % 2 == 1), "R1 sck phase", int'(sck), p % 2);
      check(req_ready === 1'b0, "R10 ready low while busy", int'(req_ready), 0);
      check(rsp_valid === 1'b0, "R9 no pulse while busy", int'(rsp_valid), 0);
      if (m_k == 1) eoe = 4'b1101;
      else if (m_k == 2) eoe = m_rx ? 4'b1100 : 4'b1111;
      else eoe = m_rx ? 4'b0000 : 4'b1111;
      check(io_oe === 4'(eoe), "R7 enables", int'(io_oe), eoe);
      if (m_k == 1)
        check(io_out[0] === sh[7], m_rx ? "R4 line0 ones" : "R2 line0 bit",
              int'(io_out[0]), int'(sh[7]));
      else if (m_k == 2 && !m_rx)
        check(io_out[1:0] === sh[7:6], "R5 dual pair", int'(io_out[1:0]), int'(sh[7:6]));
      else if (m_k == 4 && !m_rx)
        check(io_out === sh[7:4], "R6 quad nibble", int'(io_out), int'(sh[7:4]));
      if (m_k != 4)
        check(io_out[3:2] === 2'b11 && io_oe[3:2] === 2'b11, "R8 aux lines",
              int'({io_out[3:2], io_oe[3:2]}), 15);
    end else begin
      check(sck === 1'b0, "R1 sck idle", int'(sck), 0);
      check(req_ready === 1'b1, "R10 ready idle", int'(req_ready), 1);
      check(io_oe === 4'b1101 && io_out[0] === 1'b1, "R7 idle enables",
            int'(io_oe), 13);
      check(io_out[3:2] === 2'b11, "R8 aux idle", int'(io_out[3:2]), 3);
      check(rsp_valid === m_rspv, "R9 pulse", int'(rsp_valid), int'(m_rspv));
      if (m_rspv)
        check(rsp_byte === 8'(m_rsp), "R3 rx byte", int'(rsp_byte), m_rsp);
    end
    // drive inputs for this cycle
    io_in     = 4'($urandom);
    r         = int'($urandom % 8);
    req_valid = (r != 0);
    req_width = 2'($urandom);
    req_rx    = 1'($urandom);
    req_byte  = 8'($urandom);
    r         = int'($urandom % 6);
    div_half  = (r == 0) ? 4'd15 : 4'(r % 3);
    // advance model
    if (m_busy) begin
      p = m_c / m_h;
      if (p % 2 == 1 && m_c % m_h == m_h - 1) begin
        if (m_k == 1) bits = int'(io_in[1]);
        else if (m_k == 2) bits = int'(io_in[1:0]);
        else bits = int'(io_in);
        m_acc = ((m_acc << m_k) | bits) & 255;
      end
      m_c++;
      m_rspv = 0;
      if (m_c == 2 * (8 / m_k) * m_h) begin
        m_busy = 0;
        m_rspv = 1;
        m_rsp  = m_acc;
      end
    end else begin
      m_rspv = 0;
      if (req_valid) begin
        m_busy = 1;
        m_c    = 0;
        m_h    = int'(div_half) + 1;
        m_w    = (req_width == 2'd3) ? 2 : int'(req_width);
        m_k    = (m_w == 0) ? 1 : (m_w == 1) ? 2 : 4;
        m_rx   = req_rx;
        m_tx   = (m_w == 0 && req_rx) ? 255 : int'(req_byte);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready === 1'b1 && sck === 1'b0, "R1 reset idle", int'({req_ready, sck}), 2);
    check(rsp_valid === 1'b0, "R9 reset no pulse", int'(rsp_valid), 0);
    check(io_oe === 4'b1101 && io_out[3:2] === 2'b11, "R8 reset lines", int'(io_oe), 13);
    rst_n = 1'b1;
    for (int i = 0; i < STEPS; i++) step();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule